// File: doc/BRIEF.md
# Pipelined Single-Precision Floating-Point Multiplier

This block multiplies two IEEE 754 single-precision operands in a short, fixed pipeline. Both operands and their per-operation controls are captured in an input register on a rising clock edge. The first processing cycle decodes the operands, resolves special values, forms the 48-bit significand product and adds the biased exponents. All of that lands in a single internal pipeline register. The second cycle normalises, rounds under the selected mode and packs the word. The packed word and its exception flags are then written together into the output registers.

A new multiply may be presented on every clock. A result appears two edges after the edge that loads its operands. A combinational flag reports a denormal operand as soon as it sits in the input register, so that exception handling can begin early. The multiplier does not produce correct products from denormal operands; it treats them as zero. Results too small to be normal are always replaced by zero of the proper sign, and a flush-to-zero control only changes which flags accompany that zero. An active-low hold input freezes the output word and the flags while the pipeline keeps moving.

Top module: `fp32_mul_pipe`

## Requirements
- R1: A product whose operands are loaded on clock edge N is on `prod_out` and the flags after edge N+2. A new operation may be loaded on every edge, and each produces its own result in order.
- R2: Finite normal products are rounded under `rnd_mode`: 00 rounds to nearest with ties to even, 01 rounds toward zero, 10 rounds toward plus infinity and 11 rounds toward minus infinity. Words use sign bit 31, biased exponent bits 30..23 (bias 127) and fraction bits 22..0.
- R3: When the rounded exponent exceeds 254, `flg_ovf` and `flg_inx` are set. The result is infinity (exponent 255, fraction 0) when the mode rounds away from zero for that sign, or is nearest-even. Otherwise the result is the largest finite value 0x7F7FFFFF with the product's sign.
- R4: With `flush_zero` low, a rounded result whose exponent is below 1 is returned as zero with the product's sign, and both `flg_unf` and `flg_inx` are set.
- R5: With `flush_zero` high, such a result is returned as signed zero with `flg_unf` set and `flg_inx` clear.
- R6: Zero times infinity returns 0x7FC00000 with `flg_inv` set. A signalling NaN operand (exponent 255, fraction nonzero, bit 22 clear) returns 0x7FC00000 with `flg_inv` set. A quiet NaN operand (bit 22 set) returns 0x7FC00000 with `flg_inv` clear.
- R7: Infinity times a finite nonzero value returns infinity with the XOR of the signs. Zero times a finite value returns zero with the XOR of the signs. Neither case raises any flag.
- R8: `abs_a` and `abs_b` clear bit 31 of their operand before it is used.
- R9: `den_in` is high exactly while an operand in the input register has exponent 0 and a nonzero fraction. It follows the input register without an extra clock.
- R10: While `hold_n` is low at a rising edge, `prod_out` and all four registered flags keep their values. Once `hold_n` returns high, the next edge delivers the operation then in the pipeline register.
- R11: `flg_inx` is set for a normal result exactly when nonzero product bits were discarded by rounding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| abs_a | input | 1 | Use the magnitude of the first operand |
| abs_b | input | 1 | Use the magnitude of the second operand |
| rnd_mode | input | 2 | Rounding mode, loaded with the operands |
| flush_zero | input | 1 | Fast flush-to-zero mode, loaded with the operands |
| hold_n | input | 1 | Active-low freeze of result and flag registers |
| prod_out | output | 32 | Registered product |
| flg_ovf | output | 1 | Overflow flag |
| flg_unf | output | 1 | Underflow flag |
| flg_inv | output | 1 | Invalid-operation flag |
| flg_inx | output | 1 | Inexact flag |
| den_in | output | 1 | Combinational denormal-operand flag |

## Verification
The assertions assume that no denormal operand produces a result that anyone relies on. They relate only flags to the packed word, so they hold whatever a denormal product yields. The stimulus never queues an expected product for an operation with a denormal operand; denormals appear only when the combinational flag is probed. The hold property assumes reset is low across the edge it examines. The stimulus applies reset only at the start, and it lowers `hold_n` only after all queued results have drained.

// File: rtl/fp32_mul_pkg.sv
package fp32_mul_pkg;

    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int SIG_W  = FRAC_W + 1;
    localparam int PROD_W = 2 * SIG_W;
    localparam int ESUM_W = EXP_W + 2;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_MAX_NORM = (1 << EXP_W) - 2;
    localparam logic [WORD_W-1:0] QNAN_WORD = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [WORD_W-2:0] MAX_MAG   = {{(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0] frac;
    } sp_t;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_ZERO = 2'b01,
        RM_UP   = 2'b10,
        RM_DOWN = 2'b11
    } rmode_e;

    typedef enum logic [2:0] {
        CL_ZERO,
        CL_DENORM,
        CL_NORMAL,
        CL_INF,
        CL_QNAN,
        CL_SNAN
    } fclass_e;

    typedef enum logic [1:0] {
        SP_ZERO = 2'b00,
        SP_NUM  = 2'b01,
        SP_INF  = 2'b10,
        SP_NAN  = 2'b11
    } spec_e;

    typedef struct packed {
        logic ovf;
        logic unf;
        logic inv;
        logic inx;
    } flags_t;

    typedef struct packed {
        logic              sign;
        spec_e             kind;
        logic              inv;
        logic [ESUM_W-1:0] esum;
        logic [PROD_W-1:0] prod;
        rmode_e            rm;
        logic              fast;
    } stage1_t;

    function automatic fclass_e classify(input sp_t v);
        fclass_e c;
        if (v.exp == '1) begin
            if (v.frac == '0)
                c = CL_INF;
            else if (v.frac[FRAC_W-1])
                c = CL_QNAN;
            else
                c = CL_SNAN;
        end else if (v.exp == '0) begin
            c = (v.frac == '0) ? CL_ZERO : CL_DENORM;
        end else begin
            c = CL_NORMAL;
        end
        return c;
    endfunction

    function automatic logic round_inc(input rmode_e rm, input logic sign,
                                       input logic lsb, input logic rbit,
                                       input logic sticky);
        logic inc;
        case (rm)
            RM_NEAR: inc = rbit & (sticky | lsb);
            RM_ZERO: inc = 1'b0;
            RM_UP:   inc = ~sign & (rbit | sticky);
            default: inc = sign & (rbit | sticky);
        endcase
        return inc;
    endfunction

    function automatic logic ovf_to_inf(input rmode_e rm, input logic sign);
        logic r;
        case (rm)
            RM_NEAR: r = 1'b1;
            RM_ZERO: r = 1'b0;
            RM_UP:   r = ~sign;
            default: r = sign;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fp32_opread.sv
module fp32_opread
    import fp32_mul_pkg::*;
(
    input  sp_t     raw,
    input  logic    abs_en,
    output sp_t     val,
    output fclass_e cls
);
    always_comb begin
        val      = raw;
        val.sign = raw.sign & ~abs_en;
        cls      = classify(raw);
    end
endmodule

// File: rtl/fp32_stage1.sv
module fp32_stage1
    import fp32_mul_pkg::*;
(
    input  sp_t     opa,
    input  sp_t     opb,
    input  fclass_e cla,
    input  fclass_e clb,
    input  rmode_e  rm,
    input  logic    fast,
    output stage1_t s1
);
    logic a_nan, b_nan, any_snan;
    logic a_zero, b_zero, a_inf, b_inf;
    logic [SIG_W-1:0] sig_a, sig_b;

    always_comb begin
        a_nan    = (cla == CL_QNAN) || (cla == CL_SNAN);
        b_nan    = (clb == CL_QNAN) || (clb == CL_SNAN);
        any_snan = (cla == CL_SNAN) || (clb == CL_SNAN);
        // denormal operands are handled as zero
        a_zero   = (cla == CL_ZERO) || (cla == CL_DENORM);
        b_zero   = (clb == CL_ZERO) || (clb == CL_DENORM);
        a_inf    = (cla == CL_INF);
        b_inf    = (clb == CL_INF);
        sig_a    = {1'b1, opa.frac};
        sig_b    = {1'b1, opb.frac};

        s1.sign  = opa.sign ^ opb.sign;
        s1.rm    = rm;
        s1.fast  = fast;
        s1.inv   = 1'b0;
        s1.esum  = {2'b00, opa.exp} + {2'b00, opb.exp} - ESUM_W'(BIAS);
        s1.prod  = sig_a * sig_b;

        if (a_nan || b_nan) begin
            s1.kind = SP_NAN;
            s1.inv  = any_snan;
        end else if ((a_zero && b_inf) || (a_inf && b_zero)) begin
            s1.kind = SP_NAN;
            s1.inv  = 1'b1;
        end else if (a_inf || b_inf) begin
            s1.kind = SP_INF;
        end else if (a_zero || b_zero) begin
            s1.kind = SP_ZERO;
        end else begin
            s1.kind = SP_NUM;
        end
    end
endmodule

// File: rtl/fp32_round.sv
module fp32_round
    import fp32_mul_pkg::*;
(
    input  stage1_t           s1,
    output logic [WORD_W-1:0] res,
    output flags_t            flg
);
    logic                     hi;
    logic [SIG_W-1:0]         mant;
    logic                     rbit, sticky, inc, carry, lost;
    logic [SIG_W:0]           sum;
    logic [SIG_W-1:0]         mant_r;
    logic signed [ESUM_W-1:0] e_norm, e_fin;

    always_comb begin
        hi     = s1.prod[PROD_W-1];
        mant   = hi ? s1.prod[PROD_W-1 -: SIG_W] : s1.prod[PROD_W-2 -: SIG_W];
        rbit   = hi ? s1.prod[SIG_W-1] : s1.prod[SIG_W-2];
        sticky = hi ? (|s1.prod[SIG_W-2:0]) : (|s1.prod[SIG_W-3:0]);
        lost   = rbit | sticky;
        inc    = round_inc(s1.rm, s1.sign, mant[0], rbit, sticky);
        sum    = {1'b0, mant} + {{SIG_W{1'b0}}, inc};
        carry  = sum[SIG_W];
        mant_r = carry ? sum[SIG_W:1] : sum[SIG_W-1:0];
        e_norm = $signed(s1.esum) + $signed({{(ESUM_W-1){1'b0}}, hi});
        e_fin  = e_norm + $signed({{(ESUM_W-1){1'b0}}, carry});

        res = '0;
        flg = '0;
        case (s1.kind)
            SP_ZERO: res = {s1.sign, {(WORD_W-1){1'b0}}};
            SP_INF:  res = {s1.sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            SP_NAN: begin
                res     = QNAN_WORD;
                flg.inv = s1.inv;
            end
            default: begin
                if (e_fin > ESUM_W'(EXP_MAX_NORM)) begin
                    flg.ovf = 1'b1;
                    flg.inx = 1'b1;
                    if (ovf_to_inf(s1.rm, s1.sign))
                        res = {s1.sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
                    else
                        res = {s1.sign, MAX_MAG};
                end else if (e_fin < ESUM_W'(1)) begin
                    res     = {s1.sign, {(WORD_W-1){1'b0}}};
                    flg.unf = 1'b1;
                    flg.inx = ~s1.fast;
                end else begin
                    res     = {s1.sign, e_fin[EXP_W-1:0], mant_r[FRAC_W-1:0]};
                    flg.inx = lost;
                end
            end
        endcase
    end
endmodule

// File: rtl/fp32_mul_pipe.sv
module fp32_mul_pipe
    import fp32_mul_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] op_a,
    input  logic [31:0] op_b,
    input  logic        abs_a,
    input  logic        abs_b,
    input  logic [1:0]  rnd_mode,
    input  logic        flush_zero,
    input  logic        hold_n,
    output logic [31:0] prod_out,
    output logic        flg_ovf,
    output logic        flg_unf,
    output logic        flg_inv,
    output logic        flg_inx,
    output logic        den_in
);
    localparam int N_OPS = 2;

    sp_t     raw_q  [N_OPS];
    logic    abs_q  [N_OPS];
    sp_t     use_v  [N_OPS];
    fclass_e cls_v  [N_OPS];
    rmode_e  rm_q;
    logic    fast_q;
    stage1_t s1_d, s1_q;
    logic [WORD_W-1:0] res_d, res_q;
    flags_t  flg_d, flg_q;

    // input register: operands and per-operation controls
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_OPS; i++) begin
                raw_q[i] <= '0;
                abs_q[i] <= 1'b0;
            end
            rm_q   <= RM_NEAR;
            fast_q <= 1'b0;
        end else begin
            raw_q[0] <= sp_t'(op_a);
            raw_q[1] <= sp_t'(op_b);
            abs_q[0] <= abs_a;
            abs_q[1] <= abs_b;
            rm_q     <= rmode_e'(rnd_mode);
            fast_q   <= flush_zero;
        end
    end

    for (genvar g = 0; g < N_OPS; g++) begin : g_read
        fp32_opread u_read (
            .raw    (raw_q[g]),
            .abs_en (abs_q[g]),
            .val    (use_v[g]),
            .cls    (cls_v[g])
        );
    end

    assign den_in = (cls_v[0] == CL_DENORM) || (cls_v[1] == CL_DENORM);

    fp32_stage1 u_stage1 (
        .opa  (use_v[0]),
        .opb  (use_v[1]),
        .cla  (cls_v[0]),
        .clb  (cls_v[1]),
        .rm   (rm_q),
        .fast (fast_q),
        .s1   (s1_d)
    );

    // single internal pipeline register
    always_ff @(posedge clk) begin
        if (rst) s1_q <= '0;
        else     s1_q <= s1_d;
    end

    fp32_round u_round (
        .s1  (s1_q),
        .res (res_d),
        .flg (flg_d)
    );

    // output word and flags, frozen while hold_n is low
    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            flg_q <= '0;
        end else if (hold_n) begin
            res_q <= res_d;
            flg_q <= flg_d;
        end
    end

    assign prod_out = res_q;
    assign flg_ovf  = flg_q.ovf;
    assign flg_unf  = flg_q.unf;
    assign flg_inv  = flg_q.inv;
    assign flg_inx  = flg_q.inx;

    a_r10_hold_freezes: assert property (@(posedge clk) disable iff (rst)
        !hold_n |=> ($stable(prod_out) && $stable(flg_q)));

    a_r6_invalid_is_qnan: assert property (@(posedge clk) disable iff (rst)
        flg_inv |-> (prod_out == QNAN_WORD));

    a_r3_overflow_inexact: assert property (@(posedge clk) disable iff (rst)
        flg_ovf |-> (flg_inx && !flg_unf && prod_out[30:23] >= 8'hFE));

    a_r4_underflow_zero: assert property (@(posedge clk) disable iff (rst)
        flg_unf |-> (prod_out[30:0] == '0 && !flg_ovf));

    a_r5_fast_exact_flag: assert property (@(posedge clk) disable iff (rst)
        ($past(hold_n) && flg_unf && $past(s1_q.fast)) |-> !flg_inx);

    a_r7_special_inf_no_flag: assert property (@(posedge clk) disable iff (rst)
        (prod_out[30:0] == {8'hFF, 23'd0} && !flg_ovf) |-> (!flg_inx && !flg_inv));

endmodule

// File: tb/fp32_mul_pipe_bench.sv
module fp32_mul_pipe_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] op_a, op_b;
    logic        abs_a, abs_b, flush_zero, hold_n;
    logic [1:0]  rnd_mode;
    logic [31:0] prod_out;
    logic        flg_ovf, flg_unf, flg_inv, flg_inx, den_in;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    typedef struct {
        int          due;
        logic [31:0] res;
        logic [3:0]  flg;
        string       tag;
    } exp_t;
    exp_t sb[$];

    fp32_mul_pipe u_fp32_mul_pipe (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b),
        .abs_a(abs_a), .abs_b(abs_b), .rnd_mode(rnd_mode),
        .flush_zero(flush_zero), .hold_n(hold_n), .prod_out(prod_out),
        .flg_ovf(flg_ovf), .flg_unf(flg_unf), .flg_inv(flg_inv),
        .flg_inx(flg_inx), .den_in(den_in)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h/%b expected %h/%b", tag,
                     act[35:4], act[3:0], exp[35:4], exp[3:0]);
        end
    endtask

    // monitor: pops expected items when they fall due
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due == cyc) begin
            exp_t e;
            e = sb.pop_front();
            check(e.tag, {prod_out, flg_ovf, flg_unf, flg_inv, flg_inx}, {e.res, e.flg});
        end
    end

    // driver: flags are {ovf, unf, inv, inx}
    task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic [1:0] rm,
                         input logic fz, input logic aa, input logic ab,
                         input logic [31:0] er, input logic [3:0] ef, input string tag);
        exp_t e;
        @(negedge clk);
        op_a = a; op_b = b; rnd_mode = rm; flush_zero = fz; abs_a = aa; abs_b = ab;
        e.due = cyc + 3; e.res = er; e.flg = ef; e.tag = tag;
        sb.push_back(e);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; op_a = '0; op_b = '0; abs_a = 0; abs_b = 0;
        rnd_mode = 2'b00; flush_zero = 0; hold_n = 1'b1;
        repeat (3) @(negedge clk);
        check("reset state", {prod_out, flg_ovf, flg_unf, flg_inv, flg_inx}, 36'h0);
        check("reset den_in", {35'd0, den_in}, 36'd0);
        rst = 1'b0;

        // back-to-back stream, one per cycle (R1)
        issue(32'h3F800000, 32'h3F800000, 2'b00, 0, 0, 0, 32'h3F800000, 4'b0000, "R1 1*1");
        issue(32'h40000000, 32'h40400000, 2'b00, 0, 0, 0, 32'h40C00000, 4'b0000, "R1 2*3");
        issue(32'h3FC00000, 32'h3FC00000, 2'b00, 0, 0, 0, 32'h40100000, 4'b0000, "R2 1.5*1.5");
        issue(32'hBFC00000, 32'h40000000, 2'b00, 0, 0, 0, 32'hC0400000, 4'b0000, "R2 -1.5*2");
        issue(32'hBFC00000, 32'h40000000, 2'b00, 0, 1, 0, 32'h40400000, 4'b0000, "R8 abs_a");
        issue(32'h40000000, 32'hC0400000, 2'b00, 0, 0, 1, 32'h40C00000, 4'b0000, "R8 abs_b");
        issue(32'h3F800001, 32'h3F800001, 2'b00, 0, 0, 0, 32'h3F800002, 4'b0001, "R11 nearest below half");
        issue(32'h3F800001, 32'h3F800001, 2'b10, 0, 0, 0, 32'h3F800003, 4'b0001, "R2 up positive");
        issue(32'h3F800001, 32'h3F800001, 2'b01, 0, 0, 0, 32'h3F800002, 4'b0001, "R2 toward zero");
        issue(32'hBF800001, 32'h3F800001, 2'b11, 0, 0, 0, 32'hBF800003, 4'b0001, "R2 down negative");
        issue(32'hBF800001, 32'h3F800001, 2'b10, 0, 0, 0, 32'hBF800002, 4'b0001, "R2 up negative");
        issue(32'h3F800001, 32'h3FC00000, 2'b00, 0, 0, 0, 32'h3FC00002, 4'b0001, "R2 tie odd rounds up");
        issue(32'h3F800003, 32'h3FC00000, 2'b00, 0, 0, 0, 32'h3FC00004, 4'b0001, "R2 tie even stays");
        issue(32'h3F800001, 32'h3FC00000, 2'b01, 0, 0, 0, 32'h3FC00001, 4'b0001, "R2 tie toward zero");
        issue(32'h7F000000, 32'h40000000, 2'b00, 0, 0, 0, 32'h7F800000, 4'b1001, "R3 nearest to inf");
        issue(32'h7F000000, 32'h40000000, 2'b01, 0, 0, 0, 32'h7F7FFFFF, 4'b1001, "R3 zero to max");
        issue(32'h7F000000, 32'hC0000000, 2'b10, 0, 0, 0, 32'hFF7FFFFF, 4'b1001, "R3 up negative max");
        issue(32'h7F000000, 32'hC0000000, 2'b11, 0, 0, 0, 32'hFF800000, 4'b1001, "R3 down negative inf");
        issue(32'h7F000000, 32'h40000000, 2'b11, 0, 0, 0, 32'h7F7FFFFF, 4'b1001, "R3 down positive max");
        issue(32'h00800000, 32'h3F000000, 2'b00, 0, 0, 0, 32'h00000000, 4'b0101, "R4 tiny flushed");
        issue(32'h80800000, 32'h3F000000, 2'b00, 0, 0, 0, 32'h80000000, 4'b0101, "R4 tiny negative");
        issue(32'h00800000, 32'h3F800000, 2'b00, 0, 0, 0, 32'h00800000, 4'b0000, "R4 smallest normal kept");
        issue(32'h00800000, 32'h3F000000, 2'b00, 1, 0, 0, 32'h00000000, 4'b0100, "R5 fast tiny");
        issue(32'h80800000, 32'h3F000000, 2'b10, 1, 0, 0, 32'h80000000, 4'b0100, "R5 fast tiny negative");
        issue(32'h00000000, 32'h7F800000, 2'b00, 0, 0, 0, 32'h7FC00000, 4'b0010, "R6 zero*inf");
        issue(32'hFF800000, 32'h80000000, 2'b00, 0, 0, 0, 32'h7FC00000, 4'b0010, "R6 inf*zero");
        issue(32'h7FC00001, 32'h3F800000, 2'b00, 0, 0, 0, 32'h7FC00000, 4'b0000, "R6 quiet nan");
        issue(32'h3F800000, 32'h7F800001, 2'b00, 0, 0, 0, 32'h7FC00000, 4'b0010, "R6 signalling nan");
        issue(32'h7F800000, 32'hC0000000, 2'b00, 0, 0, 0, 32'hFF800000, 4'b0000, "R7 inf*-2");
        issue(32'h00000000, 32'hC0A00000, 2'b00, 0, 0, 0, 32'h80000000, 4'b0000, "R7 zero*-5");
        issue(32'hFF800000, 32'hC0000000, 2'b00, 0, 1, 0, 32'hFF800000, 4'b0000, "R8 abs on inf");
        repeat (5) @(negedge clk);

        // denormal flag follows the input register (R9)
        op_a = 32'h00000001; op_b = 32'h3F800000; abs_a = 0; abs_b = 0;
        @(negedge clk);
        check("R9 denormal a", {35'd0, den_in}, 36'd1);
        op_a = 32'h3F800000; op_b = 32'h80000005; abs_b = 1;
        @(negedge clk);
        check("R9 denormal b with abs", {35'd0, den_in}, 36'd1);
        op_a = 32'h40000000; op_b = 32'h00000000; abs_b = 0;
        @(negedge clk);
        check("R9 normal and zero", {35'd0, den_in}, 36'd0);
        repeat (3) @(negedge clk);

        // hold freezes word and flags (R10)
        issue(32'h7F000000, 32'h40000000, 2'b00, 0, 0, 0, 32'h7F800000, 4'b1001, "R10 value before hold");
        repeat (4) @(negedge clk);
        hold_n = 1'b0; op_a = 32'h3F800000; op_b = 32'h3F800000;
        repeat (4) @(negedge clk);
        check("R10 held", {prod_out, flg_ovf, flg_unf, flg_inv, flg_inx}, {32'h7F800000, 4'b1001});
        hold_n = 1'b1;
        @(negedge clk);
        check("R10 released", {prod_out, flg_ovf, flg_unf, flg_inv, flg_inx}, {32'h3F800000, 4'b0000});

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule